// File: doc/BRIEF.md
# Power-Good Strap Latch Sequencer

This block brings a clock generator out of power-off. Once the supply is reported good it waits a fixed settling interval, then watches an active-low processor power-good strobe. The first time that strobe is seen low (after a synchronizer), the block captures the three frequency-select straps and the debug-port strap together. From then on it ignores further strap and strobe edges, and it treats the same pin as an active-high power-down request. After a lock interval the outputs are declared enabled.

If the captured frequency-select code puts the part in test mode, the one-shot rule is relaxed. While the strobe is held low, the straps are captured again on every cycle, and the pin is never read as a power-down request. The captured code drives a clock-plan decode for the output dividers and is presented in the bit order the configuration readback byte uses. Both intervals are counted in reference-clock ticks, so a simulation can shorten them.

Top module: `pg_strap_seq`

## Requirements
- R1: After reset the block reports seq_state = 0 (OFF), with strap_valid, outputs_en, pd_req and freq_code all 0.
- R2: In OFF, a high supply_ok moves the block to seq_state 1 (DELAY). It leaves DELAY for seq_state 2 (WAIT) only after DELAY_TICKS ref_tick pulses have been counted. A low strobe during DELAY latches nothing.
- R3: In WAIT, the first low level of pwrgd_n seen after the SYNC_STAGES-flop synchronizer captures the straps. The captured values are freq_code = {fs_c_hi, fs_b_in, fs_a_in}, in bit positions 2, 1 and 0, which are also the readback byte's bits 2..0. The same event sets pair_is_cpu = itp_strap (1 routes the shared pair as CPU2, 0 as SRC7), sets strap_valid to 1 and moves to seq_state 3 (LOCK).
- R4: LOCK lasts LOCK_TICKS ref_tick pulses and then moves to seq_state 4 (RUN). outputs_en can be 1 only in RUN.
- R5: clk_plan decodes freq_code as follows: 011→0 (CPU 100 MHz), 001→1 (133 MHz), 010→2 (200 MHz), 000→3 (266 MHz), 10x→4 (all outputs Hi-Z), 11x→5 (reference-divided set: CPU REF/2, SRC REF/8, PCI REF/24, others REF).
- R6: test_mode equals the captured fs_c_hi. test_ref_drive is 1 only in test mode with captured fs_b_in = 1 (1 = REF/N clocks, 0 = Hi-Z).
- R7: Outside test mode, once captured, freq_code and pair_is_cpu do not change for any later strap or strobe activity until supply_ok drops.
- R8: Outside test mode, after capture, a high pwrgd_n (after synchronization) raises pd_req and forces outputs_en to 0. A low pwrgd_n releases both.
- R9: In test mode, every cycle with the synchronized strobe low captures the straps again. Strap changes while the strobe is high are ignored, and pd_req stays 0.
- R10: A low supply_ok returns the block to OFF on the next clock, clearing strap_valid and freq_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Supply-good indication, synchronous to clk |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| pwrgd_n | input | 1 | Power-good strobe (active low), later the power-down request pin |
| fs_a_in | input | 1 | Frequency-select strap, lowest bit |
| fs_b_in | input | 1 | Frequency-select strap, middle bit |
| fs_c_hi | input | 1 | Frequency-select strap top bit, already decoded as high level |
| itp_strap | input | 1 | Shared-pair routing strap |
| freq_code | output | 3 | Captured {c,b,a} code, readback order |
| strap_valid | output | 1 | Straps have been captured |
| pair_is_cpu | output | 1 | Shared pair routed as CPU2 (1) or SRC7 (0) |
| test_mode | output | 1 | Test clock mode selected |
| test_ref_drive | output | 1 | Test mode drives REF/N (1) or Hi-Z (0) |
| clk_plan | output | 3 | Decoded clock plan |
| seq_state | output | 3 | Sequencer state |
| outputs_en | output | 1 | Clock outputs enabled |
| pd_req | output | 1 | Power-down request |

## Verification
The assertions assume that supply_ok is already synchronous to clk, that ref_tick is a single-cycle pulse, and that the straps are stable in the cycle where the synchronized strobe falls. They also assume that a loss of supply can happen in any state. The bench changes every input half a cycle away from the active edge. It holds the straps steady across each capture window and moves them only at points where the requirements say they must be ignored or recaptured. It drops supply_ok between vectors, so every run starts from OFF.

// File: rtl/pg_strap_pkg.sv
package pg_strap_pkg;

  typedef enum logic [2:0] {
    SEQ_OFF   = 3'd0,
    SEQ_DELAY = 3'd1,
    SEQ_WAIT  = 3'd2,
    SEQ_LOCK  = 3'd3,
    SEQ_RUN   = 3'd4
  } seq_state_e;

  typedef enum logic [2:0] {
    PLAN_CPU100 = 3'd0,
    PLAN_CPU133 = 3'd1,
    PLAN_CPU200 = 3'd2,
    PLAN_CPU266 = 3'd3,
    PLAN_HIZ    = 3'd4,
    PLAN_REFDIV = 3'd5
  } clk_plan_e;

  typedef struct packed {
    logic fs_c;
    logic fs_b;
    logic fs_a;
    logic itp;
  } strap_t;

  // code is {c,b,a}; top bit set means a test plan
  function automatic clk_plan_e plan_of(input logic [2:0] code);
    clk_plan_e p;
    if (code[2]) begin
      p = code[1] ? PLAN_REFDIV : PLAN_HIZ;
    end else begin
      case (code[1:0])
        2'b11:   p = PLAN_CPU100;
        2'b01:   p = PLAN_CPU133;
        2'b10:   p = PLAN_CPU200;
        default: p = PLAN_CPU266;
      endcase
    end
    return p;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pg_strobe_sync.sv
module pg_strobe_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh[0] <= RST_VAL;
        else        sh[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh[i] <= RST_VAL;
        else        sh[i] <= sh[i-1];
      end
    end
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/pg_seq_fsm.sv
module pg_seq_fsm import pg_strap_pkg::*; #(
  parameter int DELAY_TICKS = 3600,
  parameter int LOCK_TICKS  = 25000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       ref_tick,
  input  logic       strobe_low,
  output seq_state_e state,
  output logic       first_sample
);
  localparam int MAXT  = max_of(DELAY_TICKS, LOCK_TICKS);
  localparam int CNT_W = (MAXT < 2) ? 1 : $clog2(MAXT + 1);
  localparam logic [CNT_W-1:0] DLY_LAST  = CNT_W'(DELAY_TICKS - 1);
  localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_TICKS - 1);

  seq_state_e       nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    nxt     = state;
    cnt_nxt = cnt;
    case (state)
      SEQ_OFF: begin
        nxt     = SEQ_DELAY;
        cnt_nxt = '0;
      end
      SEQ_DELAY: if (ref_tick) begin
        if (cnt == DLY_LAST) begin
          nxt     = SEQ_WAIT;
          cnt_nxt = '0;
        end else begin
          cnt_nxt = cnt + 1'b1;
        end
      end
      SEQ_WAIT: if (strobe_low) begin
        nxt     = SEQ_LOCK;
        cnt_nxt = '0;
      end
      SEQ_LOCK: if (ref_tick) begin
        if (cnt == LOCK_LAST) begin
          nxt     = SEQ_RUN;
          cnt_nxt = '0;
        end else begin
          cnt_nxt = cnt + 1'b1;
        end
      end
      SEQ_RUN: nxt = SEQ_RUN;
      default: nxt = SEQ_OFF;
    endcase
    if (!supply_ok) begin
      nxt     = SEQ_OFF;
      cnt_nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_OFF;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= cnt_nxt;
    end
  end

  assign first_sample = supply_ok && (state == SEQ_WAIT) && strobe_low;
endmodule

// File: rtl/pg_strap_latch.sv
module pg_strap_latch import pg_strap_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clear,
  input  logic   first_sample,
  input  logic   strobe_low,
  input  strap_t live,
  output strap_t held,
  output logic   valid,
  output logic   load
);
  logic resample;

  // test mode keeps the capture open while the strobe stays low
  assign resample = valid && held.fs_c && strobe_low;
  assign load     = first_sample || resample;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= '0;
      valid <= 1'b0;
    end else if (clear) begin
      held  <= '0;
      valid <= 1'b0;
    end else if (load) begin
      held  <= live;
      valid <= 1'b1;
    end
  end
endmodule

// File: rtl/pg_strap_seq.sv
module pg_strap_seq import pg_strap_pkg::*; #(
  parameter int DELAY_TICKS = 3600,
  parameter int LOCK_TICKS  = 25000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       ref_tick,
  input  logic       pwrgd_n,
  input  logic       fs_a_in,
  input  logic       fs_b_in,
  input  logic       fs_c_hi,
  input  logic       itp_strap,
  output logic [2:0] freq_code,
  output logic       strap_valid,
  output logic       pair_is_cpu,
  output logic       test_mode,
  output logic       test_ref_drive,
  output logic [2:0] clk_plan,
  output logic [2:0] seq_state,
  output logic       outputs_en,
  output logic       pd_req
);
  logic       strobe_hi;
  logic       strobe_low;
  logic       first_sample;
  logic       sample_evt;
  seq_state_e st;
  strap_t     live;
  strap_t     held;

  pg_strobe_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
    .clk(clk), .rst_n(rst_n), .d(pwrgd_n), .q(strobe_hi)
  );

  assign strobe_low = ~strobe_hi;

  pg_seq_fsm #(.DELAY_TICKS(DELAY_TICKS), .LOCK_TICKS(LOCK_TICKS)) fsm_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ref_tick(ref_tick),
    .strobe_low(strobe_low), .state(st), .first_sample(first_sample)
  );

  assign live = '{fs_c: fs_c_hi, fs_b: fs_b_in, fs_a: fs_a_in, itp: itp_strap};

  pg_strap_latch latch_i (
    .clk(clk), .rst_n(rst_n), .clear(~supply_ok), .first_sample(first_sample),
    .strobe_low(strobe_low), .live(live), .held(held), .valid(strap_valid),
    .load(sample_evt)
  );

  assign freq_code      = {held.fs_c, held.fs_b, held.fs_a};
  assign pair_is_cpu    = held.itp;
  assign test_mode      = held.fs_c;
  assign test_ref_drive = held.fs_c & held.fs_b;
  assign clk_plan       = plan_of(freq_code);
  assign seq_state      = st;
  assign pd_req         = strap_valid && !held.fs_c && strobe_hi;
  assign outputs_en     = (st == SEQ_RUN) && !pd_req;
endmodule

// File: rtl/pg_strap_seq_chk.sv
module pg_strap_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       supply_ok,
  input logic [2:0] seq_state,
  input logic [2:0] freq_code,
  input logic       strap_valid,
  input logic       test_mode,
  input logic       test_ref_drive,
  input logic       outputs_en,
  input logic       pd_req,
  input logic       sample_evt
);
  // R10
  supply_loss_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (seq_state == 3'd0 && !strap_valid));

  // R2
  delay_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == 3'd1 && supply_ok) |=> (seq_state == 3'd1 || seq_state == 3'd2));

  // R3
  capture_enters_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strap_valid) |-> seq_state == 3'd3);

  // R3
  sample_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_evt && supply_ok) |=> strap_valid);

  // R4
  enable_only_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outputs_en |-> seq_state == 3'd4);

  // R6
  ref_drive_needs_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_ref_drive |-> test_mode);

  // R7
  one_shot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_valid && !test_mode && supply_ok) |=> $stable(freq_code));

  // R8
  pd_blocks_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_req |-> !outputs_en);

  // R9
  test_no_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> !pd_req);
endmodule

bind pg_strap_seq pg_strap_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .seq_state(seq_state),
  .freq_code(freq_code), .strap_valid(strap_valid), .test_mode(test_mode),
  .test_ref_drive(test_ref_drive), .outputs_en(outputs_en), .pd_req(pd_req),
  .sample_evt(sample_evt)
);

// File: tb/pg_strap_seq_tb.sv
module pg_strap_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic ref_tick = 1'b0;
  logic pwrgd_n = 1'b1;
  logic fs_a_in = 1'b0, fs_b_in = 1'b0, fs_c_hi = 1'b0, itp_strap = 1'b0;
  logic [2:0] freq_code, clk_plan, seq_state;
  logic strap_valid, pair_is_cpu, test_mode, test_ref_drive, outputs_en, pd_req;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pg_strap_seq #(.DELAY_TICKS(5), .LOCK_TICKS(4), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .ref_tick(ref_tick),
    .pwrgd_n(pwrgd_n), .fs_a_in(fs_a_in), .fs_b_in(fs_b_in), .fs_c_hi(fs_c_hi),
    .itp_strap(itp_strap), .freq_code(freq_code), .strap_valid(strap_valid),
    .pair_is_cpu(pair_is_cpu), .test_mode(test_mode), .test_ref_drive(test_ref_drive),
    .clk_plan(clk_plan), .seq_state(seq_state), .outputs_en(outputs_en), .pd_req(pd_req)
  );

  // {c,b,a,itp, plan[2:0], test, ref_drive}
  localparam logic [8:0] VEC [8] = '{
    9'b0111_000_00, 9'b0010_001_00, 9'b0101_010_00, 9'b0000_011_00,
    9'b1001_100_10, 9'b1010_100_10, 9'b1101_101_11, 9'b1110_101_11
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // power cycle then bring up to WAIT with the strobe high
  task automatic bring_up(input logic [3:0] s);
    supply_ok = 1'b0; pwrgd_n = 1'b1;
    cyc(3);
    {fs_c_hi, fs_b_in, fs_a_in, itp_strap} = s;
    supply_ok = 1'b1;
    cyc(30);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      ref_tick = ~ref_tick;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1 reset state
    chk("R1 state", seq_state, 0);
    chk("R1 valid", strap_valid, 0);
    chk("R1 outputs_en", outputs_en, 0);
    chk("R1 pd_req", pd_req, 0);
    chk("R1 freq_code", freq_code, 0);

    for (int i = 0; i < 8; i++) begin
      bring_up(VEC[i][8:5]);
      chk("R2 reached wait", seq_state, 2);
      chk("R2 no capture yet", strap_valid, 0);
      pwrgd_n = 1'b0;
      cyc(4);
      chk("R4 lock state", seq_state, 3);
      chk("R4 lock disables", outputs_en, 0);
      cyc(26);
      chk("R3 freq_code", freq_code, int'(VEC[i][8:6]));
      chk("R3 pair_is_cpu", pair_is_cpu, int'(VEC[i][5]));
      chk("R3 valid", strap_valid, 1);
      chk("R5 clk_plan", clk_plan, int'(VEC[i][4:2]));
      chk("R6 test_mode", test_mode, int'(VEC[i][1]));
      chk("R6 test_ref_drive", test_ref_drive, int'(VEC[i][0]));
      chk("R4 run state", seq_state, 4);
      chk("R4 outputs_en", outputs_en, 1);
    end

    // R2: strobe already low during DELAY is not acted on
    supply_ok = 1'b0; cyc(3);
    {fs_c_hi, fs_b_in, fs_a_in, itp_strap} = 4'b0111;
    pwrgd_n = 1'b0;
    cyc(3);
    supply_ok = 1'b1;
    cyc(6);
    chk("R2 still delay", seq_state, 1);
    chk("R2 strobe ignored in delay", strap_valid, 0);
    cyc(24);
    chk("R3 capture after delay", strap_valid, 1);
    chk("R3 captured code", freq_code, 3);

    // R7 / R8: one-shot hold and power-down use of the pin
    {fs_c_hi, fs_b_in, fs_a_in, itp_strap} = 4'b1000;
    pwrgd_n = 1'b1;
    cyc(4);
    chk("R8 pd_req raised", pd_req, 1);
    chk("R8 outputs off", outputs_en, 0);
    pwrgd_n = 1'b0;
    cyc(4);
    chk("R8 pd_req released", pd_req, 0);
    chk("R8 outputs back", outputs_en, 1);
    chk("R7 code held", freq_code, 3);
    chk("R7 pair held", pair_is_cpu, 1);

    // R9: test mode recapture while strobe low
    bring_up(4'b1100);
    pwrgd_n = 1'b0;
    cyc(30);
    chk("R9 test code", freq_code, 6);
    fs_a_in = 1'b1;
    cyc(3);
    chk("R9 recapture", freq_code, 7);
    pwrgd_n = 1'b1;
    cyc(4);
    chk("R9 no pd in test", pd_req, 0);
    fs_a_in = 1'b0;
    cyc(4);
    chk("R9 hold while strobe high", freq_code, 7);

    // R10: supply loss
    supply_ok = 1'b0;
    cyc(1);
    chk("R10 state off", seq_state, 0);
    chk("R10 valid cleared", strap_valid, 0);
    chk("R10 code cleared", freq_code, 0);
    chk("R10 outputs off", outputs_en, 0);

    summary();
  end
endmodule